// File: doc/BRIEF.md
# Edge-Latching Interrupt Aggregator

This block collects up to 32 peripheral interrupt lines into one summary request for a parent interrupt controller. Each line is brought into the local clock domain and checked for a rising transition. A detected transition sets a pending flag that stays set until software clears it. A per-line enable gate decides which pending flags reach the summary output. Pending flags are recorded even for lines that are gated off, so a line that is ungated later raises the summary output at once.

Software reaches the block through a plain register port with a byte offset, a write strobe and a read strobe. The pending flags and the gate bits each have their own one-to-set and one-to-clear write locations. A handler can therefore acknowledge or gate single lines without first reading the register. Read data is registered and appears on the cycle after the read strobe.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every pending flag reads 0, every gate bit reads 1 (all lines gated off) and `irq_o` is low.
- R2: A rising transition on a source line sets its pending flag. The flag stays set after the line falls. A line held high sets the flag only once, so after a clear it stays clear.
- R3: A write to offset 0x08 clears each pending flag whose data bit is 1 and leaves flags with data bit 0 as they were.
- R4: A write to offset 0x04 sets each pending flag whose data bit is 1.
- R5: A write to offset 0x10 gates off each line whose data bit is 1. A write to offset 0x14 ungates each line whose data bit is 1. Reading offset 0x0C returns the gate bits, 1 meaning gated off. Reading offset 0x00 returns the pending flags.
- R6: `irq_o` is high exactly when at least one pending flag belongs to an ungated line. It follows a gate or flag change in the same cycle as the register update.
- R7: A transition on a gated-off line still sets its pending flag. Ungating that line then raises `irq_o`.
- R8: When a detected transition and a clear write hit the same flag in the same cycle, the flag ends up set.
- R9: Reads of any offset other than 0x00 and 0x0C return 0. Writes to 0x00, 0x0C or any unmapped offset change neither the flags nor the gate bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Peripheral interrupt lines, asynchronous, rising-edge events |
| addr_i | input | 8 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; data is returned on the next cycle |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Summary request to the parent controller |

## Verification
The assertions assume that at most one register access is presented per cycle and that the write strobe is low during reset. They also assume that the source lines change slowly enough for every level to pass through the synchronizer. The bench drives all strobes and source lines on the falling clock edge, issues single-cycle accesses one after another, and holds each source level for several cycles. It times the R8 collision by counting the synchronizer stages, so that the clear write lands on the same edge as the detected transition.

// File: rtl/irqagg_pkg.sv
// Package: shared widths and register offsets for the interrupt aggregator.
// Assumes byte offsets on a word-aligned register port.
package irqagg_pkg;
    localparam int N_SRC  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_PEND_RD = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND_SET = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_GATE_RD = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_GATE_SET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_GATE_CLR = 8'h14;
endpackage

// File: rtl/irqagg_edge.sv
// Module: irqagg_edge
// Brings each asynchronous source line into the clock domain through a
// two-flop synchronizer and emits a one-cycle pulse on each rising level.
// Assumes source levels are held long enough to be sampled.
module irqagg_edge #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] rise_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        // Synchronize the line and keep the previous synchronized level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= src_i[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // Rising level on the synchronized signal.
        assign rise_o[i] = sync_q & ~prev_q;
    end
endmodule

// File: rtl/irqagg_regs.sv
// Module: irqagg_regs
// Holds the pending flags and gate bits and decodes the register port.
// Detected transitions have priority over a same-cycle clear.
// Assumes one access per cycle; read data is registered.
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int WIDTH = N_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  rise_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    input  logic              rd_en_i,
    output logic [WIDTH-1:0]  rd_data_o,
    output logic [WIDTH-1:0]  pend_o,
    output logic [WIDTH-1:0]  gate_o
);
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] gate_q;
    logic [WIDTH-1:0] pend_set;
    logic [WIDTH-1:0] pend_clr;
    logic [WIDTH-1:0] gate_set;
    logic [WIDTH-1:0] gate_clr;
    logic [WIDTH-1:0] rd_mux;

    // Decode write strobes into per-bit set and clear vectors.
    always_comb begin
        pend_set = '0;
        pend_clr = '0;
        gate_set = '0;
        gate_clr = '0;
        if (wr_en_i) begin
            case (addr_i)
                OFS_PEND_SET: pend_set = wr_data_i;
                OFS_PEND_CLR: pend_clr = wr_data_i;
                OFS_GATE_SET: gate_set = wr_data_i;
                OFS_GATE_CLR: gate_clr = wr_data_i;
                default: ;
            endcase
        end
    end

    // Pending flags: clear first, then software set and detected edges win.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | pend_set | rise_i;
    end

    // Gate bits: all lines gated off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '1;
        else        gate_q <= (gate_q | gate_set) & ~gate_clr;
    end

    // Select read data; unmapped offsets give zero.
    always_comb begin
        case (addr_i)
            OFS_PEND_RD: rd_mux = pend_q;
            OFS_GATE_RD: rd_mux = gate_q;
            default:     rd_mux = '0;
        endcase
    end

    // Register read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_mux;
    end

    assign pend_o = pend_q;
    assign gate_o = gate_q;
endmodule

// File: rtl/irqagg_top.sv
// Module: irqagg_top
// Interrupt aggregator top: edge capture feeding latched pending flags,
// per-line gating and a single summary request.
// Assumes a single clock; source lines are asynchronous.
module irqagg_top
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [N_SRC-1:0]  wr_data_i,
    input  logic              rd_en_i,
    output logic [N_SRC-1:0]  rd_data_o,
    output logic              irq_o
);
    logic [N_SRC-1:0] rise_w;
    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] gate_w;

    irqagg_edge #(.WIDTH(N_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise_w)
    );

    irqagg_regs #(.WIDTH(N_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise_w),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .pend_o    (pend_w),
        .gate_o    (gate_w)
    );

    // Summary request: any pending flag on an ungated line.
    assign irq_o = |(pend_w & ~gate_w);
endmodule

// File: rtl/irqagg_chk.sv
// Module: irqagg_chk
// Property checker bound to irqagg_top. Assumes one access per cycle
// and no write strobe during reset.
module irqagg_chk
    import irqagg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [N_SRC-1:0]  wr_data_i,
    input logic [N_SRC-1:0]  rise_w,
    input logic [N_SRC-1:0]  pend_w,
    input logic [N_SRC-1:0]  gate_w,
    input logic              irq_o
);
    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_PEND_CLR) |=>
        ((pend_w & $past(wr_data_i) & ~$past(rise_w)) == '0));

    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_PEND_SET) |=>
        ((pend_w & $past(wr_data_i)) == $past(wr_data_i)));

    // R5
    gate_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_GATE_SET) |=>
        ((gate_w & $past(wr_data_i)) == $past(wr_data_i)));

    // R5
    gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_GATE_CLR) |=>
        ((gate_w & $past(wr_data_i)) == '0));

    // R8
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w != '0) |=> ((pend_w & $past(rise_w)) == $past(rise_w)));

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || (addr_i != OFS_GATE_SET && addr_i != OFS_GATE_CLR))
        |=> $stable(gate_w));

    // R6
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_w != '0));
endmodule

bind irqagg_top irqagg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rise_w    (rise_w),
    .pend_w    (pend_w),
    .gate_w    (gate_w),
    .irq_o     (irq_o)
);

// File: tb/test_irqagg_top.sv
// Directed bench for irqagg_top: one task per scenario.
module test_irqagg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [7:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    irqagg_top i_irqagg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr_i = a; rd_en_i = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en_i = 1'b0;
        d = rd_data_o;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); check("R1 pending", d, 32'h0);
        rd(8'h0C, d); check("R1 gate", d, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_masked_latch();
        logic [31:0] d;
        src_i[3] = 1'b1; idle(5);
        src_i[3] = 1'b0; idle(5);
        rd(8'h00, d); check("R2 held after fall", d, 32'h8);
        check("R7 gated no irq", {31'b0, irq_o}, 32'h0);
        wr(8'h14, 32'h8);
        check("R7 irq on ungate", {31'b0, irq_o}, 32'h1);
        rd(8'h0C, d); check("R5 gate read", d, 32'hFFFF_FFF7);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(8'h08, 32'h0);
        rd(8'h00, d); check("R3 zero clear", d, 32'h8);
        wr(8'h08, 32'h8);
        rd(8'h00, d); check("R3 clear", d, 32'h0);
        check("R6 irq drop", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_set_and_gate();
        logic [31:0] d;
        wr(8'h04, 32'hA000_0001);
        rd(8'h00, d); check("R4 set", d, 32'hA000_0001);
        check("R6 all gated", {31'b0, irq_o}, 32'h0);
        wr(8'h14, 32'h1);
        check("R6 ungated pending", {31'b0, irq_o}, 32'h1);
        wr(8'h10, 32'h1);
        check("R5 gate set irq", {31'b0, irq_o}, 32'h0);
        rd(8'h0C, d); check("R5 gate set read", d, 32'hFFFF_FFF7);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        src_i[5] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R8 edge beats clear", d, 32'h20);
        src_i[5] = 1'b0; idle(4);
        wr(8'h08, 32'h20);
        rd(8'h00, d); check("R8 cleared after", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(8'h18, d); check("R9 read 0x18", d, 32'h0);
        rd(8'h04, d); check("R9 read 0x04", d, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R9 pending kept", d, 32'h0);
        rd(8'h0C, d); check("R9 gate kept", d, 32'hFFFF_FFF7);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        src_i[11:8] = 4'hF; idle(6);
        rd(8'h00, d); check("R2 multi edge", d, 32'h0000_0F00);
        wr(8'h14, 32'h100);
        check("R6 one ungated", {31'b0, irq_o}, 32'h1);
        wr(8'h10, 32'h100);
        check("R6 regated", {31'b0, irq_o}, 32'h0);
        wr(8'h08, 32'h100); idle(6);
        rd(8'h00, d); check("R2 level no relatch", d, 32'h0000_0E00);
        src_i[11:8] = 4'h0; idle(4);
        wr(8'h08, 32'hFFFF_FFFF);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_latch();
        t_clear();
        t_set_and_gate();
        t_collision();
        t_unmapped();
        t_multi();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule